// File: doc/BRIEF.md
# Coincident-Select Bit Scratchpad

This block is a small bit-wide scratchpad memory in which a cell is chosen by the coincidence of one active line in a low address group and one active line in a high address group. With the default of four lines per group, the eight selection lines reach sixteen single-bit cells. No binary address is decoded. A selection counts only when each group carries exactly one high line. Any other pattern selects nothing.

Storage is changed by two separate strobes. One strobe stores a one in the selected cell and the other stores a zero. Both act on the rising clock edge. Data leaves on two complementary active-low sense lines that model an open-collector stage. Each line has a pull-down enable and a resolved level. The level is low while its enable is set and high while the line is released. When the block is idle or the selection is invalid, both lines are released.

Top module: `cosel_bitpad`

## Requirements
- R1: Selection line `k` of the low group is `sel_lines[k]`, and line `k` of the high group is `sel_lines[LO_W+k]`. A cell is selected only when exactly one line is high in each group. The selected cell number is `high_k*LO_W + low_k`, and every one of the `LO_W*HI_W` cells is distinct.
- R2: When `wr_one`=1, `wr_zero`=0 and the selection is valid at a rising clock edge, the selected cell holds 1 after that edge.
- R3: When `wr_zero`=1, `wr_one`=0 and the selection is valid at a rising clock edge, the selected cell holds 0 after that edge.
- R4: When both strobes are high at an edge, no cell changes.
- R5: For a validly selected cell that holds 1, `sense_one_oe`=1 and `sense_one_n`=0, and the zero line is released (`sense_zero_oe`=0, `sense_zero_n`=1). A cell that holds 0 gives the mirror image of this.
- R6: When all selection lines are low, both sense lines are released: both enables are 0 and both levels are 1.
- R7: For an invalid selection (a group with no high line, or with more than one), writes change no cell and both sense lines are released.
- R8: A stored value is retained through any number of cycles with the selection parked at all zeros and both strobes low.
- R9: An asynchronous active-low reset on `rst_n` clears every cell to 0.
- R10: The sense outputs follow the current selection and stored contents combinationally. A written value is visible in the first cycle after its write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes act on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, clears all cells |
| sel_lines | input | HI_W+LO_W | Coincident selection lines: the low group is in bits [LO_W-1:0] and the high group above it |
| wr_one | input | 1 | Strobe that stores 1 in the selected cell |
| wr_zero | input | 1 | Strobe that stores 0 in the selected cell |
| sense_one_oe | output | 1 | Pull-down enable of the one-sense line |
| sense_one_n | output | 1 | Resolved level of the one-sense line (low when the cell holds 1) |
| sense_zero_oe | output | 1 | Pull-down enable of the zero-sense line |
| sense_zero_n | output | 1 | Resolved level of the zero-sense line (low when the cell holds 0) |

## Verification
The bench builds the block with its default of four lines per group, giving a 16-cell array. At that size every cell can be written and read back individually, so a decode that aliases two cells shows up as a disturbed neighbour. Square groups of four also allow invalid patterns of every kind: two hot lines in one group, two in both groups, and one group empty. At this size a walking pattern and a full re-read after a mid-run reset stay within a few hundred cycles.

// File: rtl/cosel_pkg.sv
package cosel_pkg;

   // Classification of the two write strobes in one cycle.
   typedef enum logic [1:0] {
      WR_IDLE     = 2'b00,
      WR_SET      = 2'b01,
      WR_CLR      = 2'b10,
      WR_CONFLICT = 2'b11
   } wr_op_e;

   function automatic wr_op_e classify_strobes(input logic set_stb, input logic clr_stb);
      wr_op_e op;
      unique case ({clr_stb, set_stb})
         2'b01:   op = WR_SET;
         2'b10:   op = WR_CLR;
         2'b11:   op = WR_CONFLICT;
         default: op = WR_IDLE;
      endcase
      return op;
   endfunction

endpackage

// File: rtl/cosel_group_dec.sv
// Decodes one group of selection lines: reports a hit only when exactly
// one line is high, and gives the position of that line.
module cosel_group_dec #(
   parameter int W = 4,
   localparam int IW = (W > 1) ? $clog2(W) : 1
) (
   input  logic [W-1:0]  lines,
   output logic          hit,
   output logic [IW-1:0] idx
);
   localparam int CW = $clog2(W + 1);

   generate
      if (W < 2) begin : g_bad_width
         initial $error("cosel_group_dec: group width must be at least 2");
      end
   endgenerate

   logic [CW-1:0] hot_cnt;

   always_comb begin
      hot_cnt = '0;
      idx     = '0;
      for (int i = 0; i < W; i++) begin
         if (lines[i]) begin
            hot_cnt = hot_cnt + CW'(1);
            idx     = IW'(i);
         end
      end
   end

   assign hit = (hot_cnt == CW'(1));

   // R1: a hit always points at a line that is actually high
   always_comb begin
      a_r1_hit_points_high: assert (!hit || lines[idx]);
   end

endmodule

// File: rtl/cosel_cell_store.sv
// Bit-per-cell storage with separate store-one and store-zero strobes.
module cosel_cell_store
   import cosel_pkg::*;
#(
   parameter int CELLS = 16,
   localparam int CIW = (CELLS > 1) ? $clog2(CELLS) : 1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           sel_ok,
   input  logic           set_stb,
   input  logic           clr_stb,
   input  logic [CIW-1:0] cell_idx,
   output logic           rd_bit
);
   generate
      if (CELLS < 4) begin : g_bad_cells
         initial $error("cosel_cell_store: at least 4 cells required");
      end
   endgenerate

   logic [CELLS-1:0] mem;
   wr_op_e           op;

   assign op = classify_strobes(set_stb, clr_stb);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mem <= '0;
      end else if (sel_ok) begin
         case (op)
            WR_SET:  mem[cell_idx] <= 1'b1;
            WR_CLR:  mem[cell_idx] <= 1'b0;
            default: ;
         endcase
      end
   end

   assign rd_bit = sel_ok ? mem[cell_idx] : 1'b0;

   // R2: store-one writes a 1 into the chosen cell
   a_r2_set_stores: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_ok && set_stb && !clr_stb) |=> mem[$past(cell_idx)]);

   // R3: store-zero writes a 0 into the chosen cell
   a_r3_clr_stores: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_ok && clr_stb && !set_stb) |=> !mem[$past(cell_idx)]);

   // R4: both strobes together leave the array untouched
   a_r4_conflict_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (set_stb && clr_stb) |=> $stable(mem));

   // R7: no valid selection, no change
   a_r7_nosel_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!sel_ok) |=> $stable(mem));

   // R8: idle strobes retain everything
   a_r8_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!set_stb && !clr_stb) |=> $stable(mem));

endmodule

// File: rtl/cosel_sense_drv.sv
// Open-collector style sense pair: pull-down enable plus resolved level.
module cosel_sense_drv (
   input  logic sel_ok,
   input  logic bit_val,
   output logic one_oe,
   output logic one_lvl,
   output logic zero_oe,
   output logic zero_lvl
);
   assign one_oe   = sel_ok &  bit_val;
   assign zero_oe  = sel_ok & ~bit_val;
   // released line floats to the pulled-up high level
   assign one_lvl  = ~one_oe;
   assign zero_lvl = ~zero_oe;
endmodule

// File: rtl/cosel_bitpad.sv
module cosel_bitpad #(
   parameter int LO_W = 4,
   parameter int HI_W = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [HI_W+LO_W-1:0] sel_lines,
   input  logic                 wr_one,
   input  logic                 wr_zero,
   output logic                 sense_one_oe,
   output logic                 sense_one_n,
   output logic                 sense_zero_oe,
   output logic                 sense_zero_n
);
   localparam int CELLS = LO_W * HI_W;
   localparam int CIW   = $clog2(CELLS);
   localparam int LIW   = $clog2(LO_W);
   localparam int HIW   = $clog2(HI_W);

   generate
      if (LO_W < 2 || HI_W < 2) begin : g_bad_groups
         initial $error("cosel_bitpad: each group needs at least 2 lines");
      end
   endgenerate

   logic           lo_hit, hi_hit, sel_ok, rd_bit;
   logic [LIW-1:0] lo_idx;
   logic [HIW-1:0] hi_idx;
   logic [CIW-1:0] cell_idx;

   cosel_group_dec #(.W(LO_W)) u_lo_dec (
      .lines (sel_lines[LO_W-1:0]),
      .hit   (lo_hit),
      .idx   (lo_idx)
   );

   cosel_group_dec #(.W(HI_W)) u_hi_dec (
      .lines (sel_lines[HI_W+LO_W-1:LO_W]),
      .hit   (hi_hit),
      .idx   (hi_idx)
   );

   assign sel_ok   = lo_hit & hi_hit;
   assign cell_idx = CIW'(hi_idx) * CIW'(LO_W) + CIW'(lo_idx);

   cosel_cell_store #(.CELLS(CELLS)) u_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .sel_ok   (sel_ok),
      .set_stb  (wr_one),
      .clr_stb  (wr_zero),
      .cell_idx (cell_idx),
      .rd_bit   (rd_bit)
   );

   cosel_sense_drv u_sense (
      .sel_ok   (sel_ok),
      .bit_val  (rd_bit),
      .one_oe   (sense_one_oe),
      .one_lvl  (sense_one_n),
      .zero_oe  (sense_zero_oe),
      .zero_lvl (sense_zero_n)
   );

   // R6: parked selection releases both lines
   a_r6_idle_release: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_lines == '0) |-> (!sense_one_oe && !sense_zero_oe && sense_one_n && sense_zero_n));

   // R7: an invalid selection releases both lines
   a_r7_bad_release: assert property (@(posedge clk) disable iff (!rst_n)
      (!sel_ok) |-> (!sense_one_oe && !sense_zero_oe));

   // R5: a valid selection always pulls exactly one line
   a_r5_one_line_driven: assert property (@(posedge clk) disable iff (!rst_n)
      sel_ok |-> (sense_one_oe != sense_zero_oe));

   // R10: a store-one is visible next cycle at an unchanged selection
   a_r10_set_visible: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_ok && wr_one && !wr_zero) |=> (!$stable(sel_lines) || (sense_one_oe && !sense_one_n)));

   // R10: a store-zero is visible next cycle at an unchanged selection
   a_r10_clr_visible: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_ok && wr_zero && !wr_one) |=> (!$stable(sel_lines) || (sense_zero_oe && !sense_zero_n)));

endmodule

// File: tb/cosel_bitpad_tb_top.sv
module cosel_bitpad_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int LO_W  = 4;
   localparam int HI_W  = 4;
   localparam int AW    = LO_W + HI_W;
   localparam int CELLS = LO_W * HI_W;

   typedef struct {
      logic  exp_val;
      logic  exp_rel;
      string tag;
   } item_t;

   item_t sb_q[$];
   int    checks   = 0;
   int    failures = 0;
   bit    done     = 0;
   bit    model[CELLS];

   logic          clk   = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] sel   = '0;
   logic          wset  = 1'b0;
   logic          wclr  = 1'b0;
   logic          one_oe, one_n, zero_oe, zero_n;

   always #(CLK_PERIOD/2) clk = ~clk;

   cosel_bitpad #(.LO_W(LO_W), .HI_W(HI_W)) dut_i (
      .clk           (clk),
      .rst_n         (rst_n),
      .sel_lines     (sel),
      .wr_one        (wset),
      .wr_zero       (wclr),
      .sense_one_oe  (one_oe),
      .sense_one_n   (one_n),
      .sense_zero_oe (zero_oe),
      .sense_zero_n  (zero_n)
   );

   function automatic logic [AW-1:0] addr_of(input int c);
      logic [AW-1:0] a;
      a = '0;
      a[LO_W + c / LO_W] = 1'b1;
      a[c % LO_W] = 1'b1;
      return a;
   endfunction

   // Monitor: one expected item per cycle, sampled after the edge settles.
   always @(posedge clk) begin
      #1;
      if (sb_q.size() > 0) begin
         item_t it;
         logic [3:0] act, exp;
         it  = sb_q.pop_front();
         act = {one_oe, one_n, zero_oe, zero_n};
         if (it.exp_rel) exp = 4'b0101;
         else            exp = {it.exp_val, ~it.exp_val, ~it.exp_val, it.exp_val};
         checks++;
         if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%b expected=%b (one_oe,one_n,zero_oe,zero_n)",
                     it.tag, act, exp);
         end
      end
   end

   task automatic drive(input logic [AW-1:0] a, input logic s, input logic c);
      @(negedge clk);
      sel = a; wset = s; wclr = c;
   endtask

   task automatic wr_cell(input int c, input bit v);
      drive(addr_of(c), v, !v);
      model[c] = v;
   endtask

   task automatic rd_cell(input int c, input string tag);
      item_t it;
      drive(addr_of(c), 1'b0, 1'b0);
      it.exp_val = model[c]; it.exp_rel = 1'b0; it.tag = tag;
      sb_q.push_back(it);
   endtask

   task automatic rd_released(input logic [AW-1:0] a, input string tag);
      item_t it;
      drive(a, 1'b0, 1'b0);
      it.exp_val = 1'b0; it.exp_rel = 1'b1; it.tag = tag;
      sb_q.push_back(it);
   endtask

   task automatic rd_all(input string tag);
      for (int c = 0; c < CELLS; c++) rd_cell(c, tag);
   endtask

   task automatic apply_reset();
      item_t it;
      @(negedge clk);
      rst_n = 1'b0; sel = '0; wset = 1'b0; wclr = 1'b0;
      it.exp_val = 1'b0; it.exp_rel = 1'b1; it.tag = "R6 released during reset";
      sb_q.push_back(it);
      for (int c = 0; c < CELLS; c++) model[c] = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   initial begin
      for (int c = 0; c < CELLS; c++) model[c] = 1'b0;
      apply_reset();
      rd_all("R9 reset clears cell");

      // R2 / R10: store one, visible in next cycle
      wr_cell(5, 1'b1);
      rd_cell(5, "R10 set visible next cycle");
      // R3: store zero
      wr_cell(5, 1'b0);
      rd_cell(5, "R3 clear stores zero");

      // R1: walking pattern over all cells, distinct cells
      for (int c = 0; c < CELLS; c++) wr_cell(c, (c % 3) == 0);
      rd_all("R1 distinct cell pattern A");
      for (int c = 0; c < CELLS; c++) wr_cell(c, (c % 3) != 0);
      rd_all("R5 distinct cell pattern B");
      // R2: set a single cell, neighbours untouched
      wr_cell(1, 1'b1);
      rd_all("R2 set one cell only");

      // R4: both strobes high on a 1 cell and a 0 cell
      drive(addr_of(1), 1'b1, 1'b1);
      drive(addr_of(0), 1'b1, 1'b1);
      rd_cell(1, "R4 conflict keeps one");
      rd_cell(0, "R4 conflict keeps zero");

      // R7: invalid selections ignore writes and release sense lines
      drive(8'h33, 1'b1, 1'b0);
      rd_released(8'h33, "R7 two hot per group released");
      drive(8'h03, 1'b0, 1'b1);
      rd_released(8'h03, "R7 high group empty released");
      drive(8'h30, 1'b1, 1'b0);
      rd_released(8'h30, "R7 low group empty released");
      drive(8'h31, 1'b0, 1'b1);
      rd_released(8'h31, "R7 two hot high group released");
      rd_all("R7 invalid writes ignored");

      // R6 / R8: park at zero, value retained
      wr_cell(3, 1'b1);
      wr_cell(12, 1'b0);
      for (int k = 0; k < 6; k++) rd_released('0, "R6 parked released");
      rd_cell(3, "R8 retained one");
      rd_cell(12, "R8 retained zero");

      // R9: reset mid-run clears everything
      for (int c = 0; c < CELLS; c++) wr_cell(c, 1'b1);
      rd_all("R5 all ones");
      apply_reset();
      rd_all("R9 mid-run reset clears");

      drive('0, 1'b0, 1'b0);
      while (sb_q.size() > 0) @(posedge clk);
      repeat (2) @(posedge clk);
      if (!done) begin
         done = 1;
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1;
         failures++;
         $display("FAIL watchdog expired actual=hung expected=finished");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule